// File: doc/BRIEF.md
# Half-Duplex Transmit Status Generator

This block follows a single frame through a half-duplex Ethernet transmitter and turns the transmitter's event lines into one 32-bit completion word. A frame is opened by a start pulse. While it is open, the block watches deferral, collisions, carrier sense, a byte strobe, a bit-time tick and FIFO underrun. The frame is closed either by an end pulse or by any condition that aborts it. In both cases the finished word is offered for one cycle, together with an abort indication and, when the data FIFO ran dry, an underrun interrupt pulse.

The word counts collisions taken before the frame went out. It flags a collision that arrives after the collision window, a frame that hit the collision attempt limit, deferral that outlasted the watchdog, lost or absent carrier, and underrun. Bit 15 is an error summary. Backoff, the data path and statistics gathering belong to neighbouring logic.

Top module: `tx_status_gen`

## Requirements
- R1: After reset, and in every reserved position (bits 31:16, 14:12 and 7) at all times, the status word reads zero; after reset, stat_valid, tx_abort and underrun_irq are low.
- R2: Bit 15 equals the OR of bits 11, 10, 9, 8, 2 and 1 of the same word.
- R3: Bit 11 is set when carrier_in falls while the frame is open after having been seen high in that frame. Bit 10 is set when carrier_in was never high during the open frame.
- R4: A collision that arrives after 64 byte strobes have been counted in the frame sets bit 9 and aborts the frame. A collision that arrives after 63 strobes is an ordinary collision.
- R5: The 16th ordinary collision of a frame sets bit 8 and aborts the frame.
- R6: Bits 6:3 hold the number of ordinary collisions of the frame (binary, LSB at bit 3). The field is unspecified when bit 8 is set.
- R7: When defer_chk_en is high, the 24289th bit_tick seen while defer_in stays continuously high sets bit 2 and aborts the frame. The tick count restarts whenever defer_in goes low. With defer_chk_en low, bit 2 never sets.
- R8: An underrun_in pulse during the frame sets bit 1, aborts the frame and gives one underrun_irq pulse in the same cycle as stat_valid.
- R9: Bit 0 is set if defer_in was high during any cycle of the open frame.
- R10: frame_start clears all status and counters. Events in the frame_start cycle and while no frame is open are ignored. stat_valid is high for exactly one cycle, the cycle after the frame_end pulse or the aborting event, and the word then holds until the next frame_start.
- R11: tx_abort is high together with stat_valid when, and only when, the frame was closed by an abort (R4, R5, R7, R8) and not by frame_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Opens a frame and clears status |
| frame_end | input | 1 | Normal completion of the open frame |
| byte_strobe | input | 1 | One byte sent on the wire |
| bit_tick | input | 1 | One bit time elapsed |
| defer_in | input | 1 | Transmitter is deferring |
| defer_chk_en | input | 1 | Enables the excessive-deferral watchdog |
| collision_in | input | 1 | Collision pulse |
| carrier_in | input | 1 | Carrier sense level |
| underrun_in | input | 1 | Transmit data FIFO underrun pulse |
| stat_word | output | 32 | Completion status word |
| stat_valid | output | 1 | One-cycle strobe for stat_word |
| tx_abort | output | 1 | Frame was ended by an abort |
| underrun_irq | output | 1 | Underrun interrupt pulse |

## Verification
Every event seen in the open frame shows up in the status word, in stat_valid, tx_abort and underrun_irq exactly one clock edge later. This is because the block has one register stage between the event inputs and the outputs. The bench drives its inputs on falling edges and samples the outputs on falling edges. A monitor counts each valid strobe, captures the word in the cycle the strobe is high, and a check confirms that each frame produced exactly one strobe. Held-word and ignored-event checks read the outputs several cycles later, when no further change is legal.

// File: rtl/txs_pkg.sv
package txs_pkg;

  localparam int unsigned CNT_FIELD_W = 4;

  typedef struct packed {
    logic                   lost_carr;
    logic                   no_carr;
    logic                   late_coll;
    logic                   excess_coll;
    logic [CNT_FIELD_W-1:0] coll_cnt;
    logic                   excess_defer;
    logic                   underrun;
    logic                   deferred;
  } txs_flags_t;

  // Place the flags in the status word; reserved positions stay zero.
  function automatic logic [31:0] txs_pack(input txs_flags_t f);
    logic [31:0] w;
    w       = '0;
    w[0]    = f.deferred;
    w[1]    = f.underrun;
    w[2]    = f.excess_defer;
    w[6:3]  = f.coll_cnt;
    w[8]    = f.excess_coll;
    w[9]    = f.late_coll;
    w[10]   = f.no_carr;
    w[11]   = f.lost_carr;
    w[15]   = f.lost_carr | f.no_carr | f.late_coll | f.excess_coll |
              f.excess_defer | f.underrun;
    return w;
  endfunction

  // Clamp a wider count into the status field.
  function automatic logic [CNT_FIELD_W-1:0] txs_clamp(input logic [7:0] n);
    logic [7:0] top;
    top = 8'((1 << CNT_FIELD_W) - 1);
    return (n > top) ? CNT_FIELD_W'(top) : n[CNT_FIELD_W-1:0];
  endfunction

endpackage

// File: rtl/txs_coll_track.sv
module txs_coll_track #(
  parameter int unsigned WINDOW_BYTES = 64,
  parameter int unsigned MAX_COLL     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       byte_strobe,
  input  logic       collision_in,
  output logic [3:0] coll_cnt,
  output logic       late_ev,
  output logic       excess_ev,
  output logic       late_flag,
  output logic       excess_flag
);
  localparam int unsigned BW = $clog2(WINDOW_BYTES + 1);
  localparam int unsigned CW = $clog2(MAX_COLL + 1);

  logic [BW-1:0] byte_cnt;
  logic [CW-1:0] tries;
  logic          window_done;
  logic          coll_ev;
  logic          norm_ev;

  assign window_done = (byte_cnt == BW'(WINDOW_BYTES));
  assign coll_ev     = en && collision_in;
  assign late_ev     = coll_ev && window_done;
  assign norm_ev     = coll_ev && !window_done;
  assign excess_ev   = norm_ev && (tries == CW'(MAX_COLL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt    <= '0;
      tries       <= '0;
      late_flag   <= 1'b0;
      excess_flag <= 1'b0;
    end else if (clr) begin
      byte_cnt    <= '0;
      tries       <= '0;
      late_flag   <= 1'b0;
      excess_flag <= 1'b0;
    end else begin
      if (en && byte_strobe && !window_done) byte_cnt <= byte_cnt + 1'b1;
      if (norm_ev && tries != CW'(MAX_COLL)) tries <= tries + 1'b1;
      if (late_ev)   late_flag   <= 1'b1;
      if (excess_ev) excess_flag <= 1'b1;
    end
  end

  assign coll_cnt = txs_pkg::txs_clamp(8'(tries));
endmodule

// File: rtl/txs_defer_watch.sv
module txs_defer_watch #(
  parameter int unsigned DEFER_LIMIT = 24288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic defer_in,
  input  logic bit_tick,
  input  logic chk_en,
  output logic deferred_flag,
  output logic xdefer_ev,
  output logic xdefer_flag
);
  localparam int unsigned DW = $clog2(DEFER_LIMIT + 1);

  logic [DW-1:0] ticks;
  logic          deferring;
  logic          counting;

  assign deferring = en && defer_in;
  assign counting  = deferring && chk_en && bit_tick;
  assign xdefer_ev = counting && (ticks == DW'(DEFER_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks         <= '0;
      deferred_flag <= 1'b0;
      xdefer_flag   <= 1'b0;
    end else if (clr) begin
      ticks         <= '0;
      deferred_flag <= 1'b0;
      xdefer_flag   <= 1'b0;
    end else begin
      if (!deferring)
        ticks <= '0;
      else if (counting && ticks != DW'(DEFER_LIMIT))
        ticks <= ticks + 1'b1;
      if (deferring) deferred_flag <= 1'b1;
      if (xdefer_ev) xdefer_flag   <= 1'b1;
    end
  end
endmodule

// File: rtl/txs_carrier_mon.sv
module txs_carrier_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic done,
  input  logic carrier_in,
  output logic lost_ev,
  output logic lost_flag,
  output logic no_carr_flag
);
  logic seen;

  assign lost_ev = en && seen && !carrier_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen         <= 1'b0;
      lost_flag    <= 1'b0;
      no_carr_flag <= 1'b0;
    end else if (clr) begin
      seen         <= 1'b0;
      lost_flag    <= 1'b0;
      no_carr_flag <= 1'b0;
    end else begin
      if (en && carrier_in) seen      <= 1'b1;
      if (lost_ev)          lost_flag <= 1'b1;
      if (done) no_carr_flag <= !(seen || (en && carrier_in));
    end
  end
endmodule

// File: rtl/tx_status_gen.sv
module tx_status_gen #(
  parameter int unsigned WINDOW_BYTES = 64,
  parameter int unsigned MAX_COLL     = 16,
  parameter int unsigned DEFER_LIMIT  = 24288
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  input  logic        frame_end,
  input  logic        byte_strobe,
  input  logic        bit_tick,
  input  logic        defer_in,
  input  logic        defer_chk_en,
  input  logic        collision_in,
  input  logic        carrier_in,
  input  logic        underrun_in,
  output logic [31:0] stat_word,
  output logic        stat_valid,
  output logic        tx_abort,
  output logic        underrun_irq
);
  import txs_pkg::*;

  logic       active;
  logic       en;
  logic       finish;
  logic       abort_ev;
  logic       unr_ev;
  logic       unr_flag;
  logic       late_ev, excess_ev, xdefer_ev, lost_ev;
  logic       late_flag, excess_flag, xdefer_flag, deferred_flag;
  logic       lost_flag, no_carr_flag;
  logic [3:0] coll_cnt;
  txs_flags_t flags;

  assign en       = active && !frame_start;
  assign unr_ev   = en && underrun_in;
  assign abort_ev = late_ev | excess_ev | xdefer_ev | unr_ev;
  assign finish   = en && (frame_end || abort_ev);

  txs_coll_track #(.WINDOW_BYTES(WINDOW_BYTES), .MAX_COLL(MAX_COLL)) u_coll (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .en(en),
    .byte_strobe(byte_strobe), .collision_in(collision_in),
    .coll_cnt(coll_cnt), .late_ev(late_ev), .excess_ev(excess_ev),
    .late_flag(late_flag), .excess_flag(excess_flag)
  );

  txs_defer_watch #(.DEFER_LIMIT(DEFER_LIMIT)) u_defer (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .en(en),
    .defer_in(defer_in), .bit_tick(bit_tick), .chk_en(defer_chk_en),
    .deferred_flag(deferred_flag), .xdefer_ev(xdefer_ev),
    .xdefer_flag(xdefer_flag)
  );

  txs_carrier_mon u_carr (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .en(en), .done(finish),
    .carrier_in(carrier_in), .lost_ev(lost_ev), .lost_flag(lost_flag),
    .no_carr_flag(no_carr_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= 1'b0;
      unr_flag     <= 1'b0;
      stat_valid   <= 1'b0;
      tx_abort     <= 1'b0;
      underrun_irq <= 1'b0;
    end else begin
      if (frame_start)  active <= 1'b1;
      else if (finish)  active <= 1'b0;
      if (frame_start)  unr_flag <= 1'b0;
      else if (unr_ev)  unr_flag <= 1'b1;
      stat_valid   <= finish;
      tx_abort     <= en && abort_ev;
      underrun_irq <= unr_ev;
    end
  end

  always_comb begin
    flags.lost_carr    = lost_flag;
    flags.no_carr      = no_carr_flag;
    flags.late_coll    = late_flag;
    flags.excess_coll  = excess_flag;
    flags.coll_cnt     = coll_cnt;
    flags.excess_defer = xdefer_flag;
    flags.underrun     = unr_flag;
    flags.deferred     = deferred_flag;
  end

  assign stat_word = txs_pack(flags);
endmodule

// File: rtl/txs_checker.sv
module txs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic [31:0] stat_word,
  input logic        stat_valid,
  input logic        tx_abort,
  input logic        underrun_irq,
  input logic        late_ev,
  input logic        excess_ev,
  input logic        xdefer_ev,
  input logic [3:0]  coll_cnt
);
  // R2
  a_r2_summary_or: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_word[15] == (|{stat_word[11:8], stat_word[2:1]})));
  // R4
  a_r4_late_closes: assert property (@(posedge clk) disable iff (!rst_n)
    late_ev |=> (stat_valid && stat_word[9] && tx_abort));
  // R5
  a_r5_excess_closes: assert property (@(posedge clk) disable iff (!rst_n)
    excess_ev |=> (stat_valid && stat_word[8] && tx_abort));
  // R6
  a_r6_count_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    excess_ev |-> (coll_cnt == 4'd15));
  // R7
  a_r7_defer_closes: assert property (@(posedge clk) disable iff (!rst_n)
    xdefer_ev |=> (stat_valid && stat_word[2] && tx_abort));
  // R8
  a_r8_irq_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_irq |-> (stat_valid && stat_word[1] && tx_abort));
  // R10
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);
  a_r10_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !frame_start) |=> $stable(stat_word));
  // R11
  a_r11_abort_has_word: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> stat_valid);
endmodule

bind tx_status_gen txs_checker u_txs_checker (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .stat_word(stat_word),
  .stat_valid(stat_valid), .tx_abort(tx_abort), .underrun_irq(underrun_irq),
  .late_ev(late_ev), .excess_ev(excess_ev), .xdefer_ev(xdefer_ev),
  .coll_cnt(coll_cnt)
);

// File: tb/tx_status_gen_bench.sv
module tx_status_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 0, frame_end = 0, byte_strobe = 0, bit_tick = 0;
  logic        defer_in = 0, defer_chk_en = 0, collision_in = 0;
  logic        carrier_in = 0, underrun_in = 0;
  logic [31:0] stat_word;
  logic        stat_valid, tx_abort, underrun_irq;

  int checks = 0, errors = 0;
  int vcnt = 0, acnt = 0, icnt = 0;
  logic [31:0] cap_word = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  tx_status_gen u_tx_status_gen (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .byte_strobe(byte_strobe), .bit_tick(bit_tick), .defer_in(defer_in),
    .defer_chk_en(defer_chk_en), .collision_in(collision_in),
    .carrier_in(carrier_in), .underrun_in(underrun_in),
    .stat_word(stat_word), .stat_valid(stat_valid), .tx_abort(tx_abort),
    .underrun_irq(underrun_irq)
  );

  // carr: 0 never present, 1 held, 2 dropped mid-frame
  typedef struct packed {
    logic [15:0] defer;
    logic [4:0]  colls;
    logic [6:0]  bytes;
    logic [1:0]  carr;
    logic        late;
    logic        unr;
    logic        en;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{16'd0, 5'd0,  7'd10, 2'd1, 1'b0, 1'b0, 1'b0},
    '{16'd0, 5'd0,  7'd4,  2'd0, 1'b0, 1'b0, 1'b0},
    '{16'd0, 5'd3,  7'd20, 2'd1, 1'b0, 1'b0, 1'b0},
    '{16'd5, 5'd0,  7'd2,  2'd1, 1'b0, 1'b0, 1'b1},
    '{16'd0, 5'd0,  7'd8,  2'd2, 1'b0, 1'b0, 1'b0},
    '{16'd0, 5'd15, 7'd3,  2'd1, 1'b0, 1'b0, 1'b0},
    '{16'd0, 5'd2,  7'd64, 2'd1, 1'b1, 1'b0, 1'b0},
    '{16'd0, 5'd0,  7'd63, 2'd1, 1'b1, 1'b0, 1'b0},
    '{16'd0, 5'd0,  7'd5,  2'd1, 1'b0, 1'b1, 1'b0},
    '{16'd0, 5'd16, 7'd3,  2'd1, 1'b0, 1'b0, 1'b0}
  };

  always @(negedge clk) begin
    if (stat_valid) begin
      vcnt++;
      cap_word = stat_word;
      if (tx_abort) acnt++;
    end
    if (underrun_irq) icnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input vec_t v);
    logic [31:0] w;
    bit excess, late_hit, xdef;
    int ncoll;
    excess   = v.colls >= 16;
    late_hit = v.late && v.bytes >= 64 && !excess;
    ncoll    = v.colls + ((v.late && v.bytes < 64) ? 1 : 0);
    xdef     = v.en && v.defer > 24288;
    w = '0;
    w[0]  = v.defer != 0;
    w[1]  = v.unr && !excess && !xdef;
    w[2]  = xdef;
    w[6:3] = excess ? 4'd0 : ncoll[3:0];
    w[8]  = excess;
    w[9]  = late_hit;
    w[10] = v.carr == 0;
    w[11] = v.carr == 2 && !excess && !xdef;
    w[15] = w[11] | w[10] | w[9] | w[8] | w[2] | w[1];
    return w;
  endfunction

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic run_frame(input vec_t v, input string tag);
    int v0, a0, i0;
    logic [31:0] exp, mask;
    bit ab;
    v0 = vcnt; a0 = acnt; i0 = icnt;
    @(negedge clk);
    defer_chk_en = v.en;
    pulse(frame_start);
    carrier_in = (v.carr != 0);
    if (v.defer != 0) begin
      defer_in = 1; bit_tick = 1;
      repeat (int'(v.defer)) @(negedge clk);
      defer_in = 0; bit_tick = 0;
    end
    for (int k = 0; k < int'(v.colls); k++) begin
      pulse(collision_in); @(negedge clk);
    end
    for (int k = 0; k < int'(v.bytes); k++) pulse(byte_strobe);
    if (v.carr == 2) begin carrier_in = 0; @(negedge clk); end
    if (v.late) pulse(collision_in);
    if (v.unr) pulse(underrun_in);
    pulse(frame_end);
    carrier_in = 0;
    repeat (2) @(negedge clk);
    exp  = expect_word(v);
    mask = (v.colls >= 16) ? 32'hFFFF_FF87 : 32'hFFFF_FFFF;
    ab   = (v.colls >= 16) || (v.late && v.bytes >= 64) || v.unr ||
           (v.en && v.defer > 24288);
    chk({tag, " R10 one strobe"}, vcnt - v0, 1);
    chk({tag, " word R1 R2 R3 R4 R5 R6 R7 R8 R9"}, cap_word & mask, exp & mask);
    chk({tag, " R11 abort"}, acnt - a0, ab ? 1 : 0);
    chk({tag, " R8 irq"}, icnt - i0, v.unr ? 1 : 0);
  endtask

  initial begin
    vec_t d;
    int v0, i0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", stat_word, 32'h0);
    chk("R1 reset strobes", {29'd0, stat_valid, tx_abort, underrun_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) run_frame(TBL[n], $sformatf("vec%0d", n));

    // R10: word held after the strobe
    repeat (3) @(negedge clk);
    chk("R10 word held", stat_word, cap_word);

    // R10: events with no open frame are ignored
    v0 = vcnt; i0 = icnt;
    pulse(collision_in); pulse(underrun_in); pulse(frame_end);
    repeat (2) @(negedge clk);
    chk("R10 idle no strobe", vcnt - v0, 0);
    chk("R10 idle no irq", icnt - i0, 0);
    chk("R10 idle word", stat_word, cap_word);

    // R7: one tick past the limit aborts
    d = '{16'd24289, 5'd0, 7'd0, 2'd1, 1'b0, 1'b0, 1'b1};
    run_frame(d, "R7 over");
    // R7: exactly at the limit does not
    d = '{16'd24288, 5'd0, 7'd1, 2'd1, 1'b0, 1'b0, 1'b1};
    run_frame(d, "R7 at");
    // R7: disabled never sets
    d = '{16'd24300, 5'd0, 7'd1, 2'd1, 1'b0, 1'b0, 1'b0};
    run_frame(d, "R7 off");

    // R7: count restarts when deferral ends
    v0 = vcnt;
    defer_chk_en = 1;
    pulse(frame_start);
    carrier_in = 1; defer_in = 1; bit_tick = 1;
    repeat (20000) @(negedge clk);
    defer_in = 0; @(negedge clk);
    defer_in = 1;
    repeat (20000) @(negedge clk);
    defer_in = 0; bit_tick = 0;
    pulse(frame_end);
    carrier_in = 0;
    repeat (2) @(negedge clk);
    chk("R7 restart strobe", vcnt - v0, 1);
    chk("R7 restart word", cap_word, 32'h0000_0001);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule